// File: doc/BRIEF.md
# Trap entry sequencer

This block carries out the architectural bookkeeping of entering a trap. When a single-cycle request arrives with a 9-bit trap type, it raises the trap level and emits one write to an external per-level trap stack. That write holds the interrupted program counter, the next program counter, the trap type and a caller-supplied state word. It also adjusts the register-window pointer for window-management traps and forms the vector fetch address from either the ordinary or the hypervisor trap base. Every result is registered and commits on the clock edge after the request.

The trap level, the red-state flag and the error flag live inside the block. A reset clears all three. The current PC, next PC, window pointer, can-save count, the two base registers, the mode flag and the maximum level are inputs, sampled in the cycle of the request. If a request arrives while the level has already reached the maximum, the block enters the error state and changes nothing else.

Top module: `trap_entry_seq`

## Requirements
- R1: A request while trap_level >= max_level sets error_state and leaves trap_level, red_state, new_pc, new_npc and new_cwp unchanged. No stack write is issued.
- R2: A request while trap_level + 1 < max_level increments trap_level by one and leaves red_state unchanged.
- R3: A request while trap_level + 1 == max_level sets red_state and increments trap_level to max_level. red_state and error_state stay set until reset.
- R4: An accepted trap pulses stk_we high for exactly one cycle, in the cycle after the request. In that cycle stk_idx is the low IDX_W bits of the new trap level, and stk_pc, stk_npc, stk_tt and stk_state carry the values of cur_pc, cur_npc, trap_type and cur_state at the request.
- R5: With hyp_mode low, new_pc is trap_base with bits 14:0 cleared, ORed with trap_type shifted left by 5, and ORed with bit 14 when the new trap level exceeds 1.
- R6: With hyp_mode high, new_pc is hyp_trap_base with bits 13:0 cleared, ORed with trap_type shifted left by 5.
- R7: new_npc equals new_pc + 4 after every accepted trap.
- R8: Trap type 0x024 (clean window) sets new_cwp to cur_cwp - 1, modulo NWIN.
- R9: A trap type whose bits 8:6 are 3'b010 (spill) sets new_cwp to cur_cwp - cur_cansave - 2, modulo NWIN.
- R10: A trap type whose bits 8:6 are 3'b011 (fill) sets new_cwp to cur_cwp + 1, modulo NWIN.
- R11: For any other accepted trap type, new_cwp takes cur_cwp unchanged.
- R12: After reset, trap_level, red_state, error_state, stk_we, new_pc, new_npc and new_cwp are all zero.
- R13: A cycle without a request changes no output and produces no stack write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Single-cycle trap request |
| trap_type | input | 9 | Trap type of the request |
| cur_pc | input | ADDR_W | Program counter being interrupted |
| cur_npc | input | ADDR_W | Next program counter being interrupted |
| cur_state | input | STATE_W | State word saved on the stack |
| cur_cwp | input | CWP_W | Current window pointer |
| cur_cansave | input | CWP_W | Current can-save window count |
| trap_base | input | ADDR_W | Ordinary trap base address |
| hyp_trap_base | input | ADDR_W | Hypervisor trap base address |
| hyp_mode | input | 1 | Selects the hypervisor vector form |
| max_level | input | TL_W | Maximum trap level |
| new_pc | output | ADDR_W | Vector fetch address |
| new_npc | output | ADDR_W | Vector next fetch address |
| trap_level | output | TL_W | Current trap level |
| error_state | output | 1 | Sticky fatal error flag |
| red_state | output | 1 | Sticky red-state flag |
| new_cwp | output | CWP_W | Window pointer after the trap |
| stk_we | output | 1 | Trap stack write strobe |
| stk_idx | output | IDX_W | Trap stack entry index |
| stk_state | output | STATE_W | State word to store |
| stk_pc | output | ADDR_W | PC to store |
| stk_npc | output | ADDR_W | Next PC to store |
| stk_tt | output | 9 | Trap type to store |

## Verification
The bench builds the block with NWIN = 8, TL_W = 4 and IDX_W = 3. These values let it sweep every pair of window pointer and can-save count for the spill, fill, clean-window and plain trap classes. They also let the level climb past the stack depth, so the index masking is exercised. It repeats the climb from reset for maximum levels 0, 1, 2, 3, 5 and 15. Each climb passes through levels 0, 1, max-1 and max and ends with traps in the error state. Along the way it alternates hypervisor mode so both vector forms and the bit-14 rule appear at every level.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  localparam int TT_W = 9;

  // trap type of the clean-window trap
  localparam logic [TT_W-1:0] TT_CLEAN_WIN = 9'h024;
  // group codes in trap type bits 8:6
  localparam logic [2:0] GRP_SPILL = 3'b010;
  localparam logic [2:0] GRP_FILL  = 3'b011;

  typedef enum logic [1:0] {
    WOP_KEEP,
    WOP_CLEAN,
    WOP_SPILL,
    WOP_FILL
  } win_op_e;

endpackage

// File: rtl/trap_level_ctl.sv
module trap_level_ctl #(
  parameter int TL_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trap_req,
  input  logic [TL_W-1:0] max_level,
  output logic            accept,
  output logic [TL_W-1:0] tl_next,
  output logic [TL_W-1:0] tl_q,
  output logic            red_q,
  output logic            err_q
);

  logic below_last;

  always_comb begin
    accept     = trap_req && (tl_q < max_level);
    below_last = ({1'b0, tl_q} + {{TL_W{1'b0}}, 1'b1}) < {1'b0, max_level};
    tl_next    = tl_q + TL_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tl_q  <= '0;
      red_q <= 1'b0;
      err_q <= 1'b0;
    end else if (trap_req) begin
      if (!accept) begin
        err_q <= 1'b1;
      end else begin
        tl_q <= tl_next;
        if (!below_last) red_q <= 1'b1;
      end
    end
  end

  assert_error_freezes_R1: assert property (@(posedge clk) disable iff (rst)
    (trap_req && (tl_q >= max_level)) |=> (err_q && (tl_q == $past(tl_q)) && (red_q == $past(red_q))));

  assert_level_step_R2: assert property (@(posedge clk) disable iff (rst)
    (trap_req && (tl_q < max_level)) |=> (tl_q == $past(tl_q) + TL_W'(1)));

  assert_red_on_last_R3: assert property (@(posedge clk) disable iff (rst)
    (trap_req && (tl_q < max_level) && !below_last) |=> red_q);

  assert_flags_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    !$fell(red_q) && !$fell(err_q));

endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen #(
  parameter int ADDR_W = 64,
  parameter int TL_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [TL_W-1:0]   tl_next,
  input  logic [8:0]        tt,
  input  logic              hyp,
  input  logic [ADDR_W-1:0] tba,
  input  logic [ADDR_W-1:0] htba,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] npc_q
);

  localparam logic [ADDR_W-1:0] ORD_MASK = ~ADDR_W'(32'h7fff);
  localparam logic [ADDR_W-1:0] HYP_MASK = ~ADDR_W'(32'h3fff);
  localparam logic [ADDR_W-1:0] UPPER_BIT = ADDR_W'(32'h4000);

  logic [ADDR_W-1:0] tt_off;
  logic [ADDR_W-1:0] vec;

  always_comb begin
    tt_off = ADDR_W'({tt, 5'b00000});
    if (hyp) begin
      vec = (htba & HYP_MASK) | tt_off;
    end else begin
      vec = (tba & ORD_MASK) | tt_off | ((tl_next > TL_W'(1)) ? UPPER_BIT : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      npc_q <= '0;
    end else if (load) begin
      pc_q  <= vec;
      npc_q <= vec + ADDR_W'(4);
    end
  end

  assert_npc_follows_R7: assert property (@(posedge clk) disable iff (rst)
    load |=> (npc_q - pc_q == ADDR_W'(4)));

  assert_hyp_base_R6: assert property (@(posedge clk) disable iff (rst)
    (load && hyp) |=> (pc_q[ADDR_W-1:14] == $past(htba[ADDR_W-1:14])));

endmodule

// File: rtl/trap_window_adj.sv
module trap_window_adj
  import trap_entry_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int CWP_W = $clog2(NWIN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [8:0]       tt,
  input  logic [CWP_W-1:0] cwp,
  input  logic [CWP_W-1:0] cansave,
  output logic [CWP_W-1:0] cwp_q
);

  win_op_e          op;
  logic [CWP_W-1:0] cwp_n;

  always_comb begin
    if (tt == TT_CLEAN_WIN)       op = WOP_CLEAN;
    else if (tt[8:6] == GRP_SPILL) op = WOP_SPILL;
    else if (tt[8:6] == GRP_FILL)  op = WOP_FILL;
    else                           op = WOP_KEEP;
  end

  // window count is a power of two, so CWP_W-bit arithmetic wraps correctly
  always_comb begin
    unique case (op)
      WOP_CLEAN: cwp_n = cwp - CWP_W'(1);
      WOP_SPILL: cwp_n = cwp - cansave - CWP_W'(2);
      WOP_FILL:  cwp_n = cwp + CWP_W'(1);
      default:   cwp_n = cwp;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       cwp_q <= '0;
    else if (load) cwp_q <= cwp_n;
  end

  assert_clean_dec_R8: assert property (@(posedge clk) disable iff (rst)
    (load && (tt == TT_CLEAN_WIN)) |=> (cwp_q + CWP_W'(1) == $past(cwp)));

  assert_fill_inc_R10: assert property (@(posedge clk) disable iff (rst)
    (load && (tt[8:6] == GRP_FILL)) |=> (cwp_q == $past(cwp) + CWP_W'(1)));

endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq #(
  parameter int ADDR_W  = 64,
  parameter int STATE_W = 32,
  parameter int TL_W    = 4,
  parameter int IDX_W   = 3,
  parameter int NWIN    = 8,
  localparam int CWP_W  = $clog2(NWIN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trap_req,
  input  logic [8:0]         trap_type,
  input  logic [ADDR_W-1:0]  cur_pc,
  input  logic [ADDR_W-1:0]  cur_npc,
  input  logic [STATE_W-1:0] cur_state,
  input  logic [CWP_W-1:0]   cur_cwp,
  input  logic [CWP_W-1:0]   cur_cansave,
  input  logic [ADDR_W-1:0]  trap_base,
  input  logic [ADDR_W-1:0]  hyp_trap_base,
  input  logic               hyp_mode,
  input  logic [TL_W-1:0]    max_level,
  output logic [ADDR_W-1:0]  new_pc,
  output logic [ADDR_W-1:0]  new_npc,
  output logic [TL_W-1:0]    trap_level,
  output logic               error_state,
  output logic               red_state,
  output logic [CWP_W-1:0]   new_cwp,
  output logic               stk_we,
  output logic [IDX_W-1:0]   stk_idx,
  output logic [STATE_W-1:0] stk_state,
  output logic [ADDR_W-1:0]  stk_pc,
  output logic [ADDR_W-1:0]  stk_npc,
  output logic [8:0]         stk_tt
);

  logic            accept;
  logic [TL_W-1:0] tl_next;
  logic [IDX_W-1:0] idx_next;

  trap_level_ctl #(.TL_W(TL_W)) u_level (
    .clk(clk), .rst(rst), .trap_req(trap_req), .max_level(max_level),
    .accept(accept), .tl_next(tl_next), .tl_q(trap_level),
    .red_q(red_state), .err_q(error_state)
  );

  trap_vector_gen #(.ADDR_W(ADDR_W), .TL_W(TL_W)) u_vector (
    .clk(clk), .rst(rst), .load(accept), .tl_next(tl_next), .tt(trap_type),
    .hyp(hyp_mode), .tba(trap_base), .htba(hyp_trap_base),
    .pc_q(new_pc), .npc_q(new_npc)
  );

  trap_window_adj #(.NWIN(NWIN), .CWP_W(CWP_W)) u_window (
    .clk(clk), .rst(rst), .load(accept), .tt(trap_type),
    .cwp(cur_cwp), .cansave(cur_cansave), .cwp_q(new_cwp)
  );

  // stack index: new level masked to the stack index width
  generate
    if (IDX_W < TL_W) begin : g_idx_mask
      assign idx_next = tl_next[IDX_W-1:0];
    end else begin : g_idx_wide
      assign idx_next = IDX_W'(tl_next);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      stk_we    <= 1'b0;
      stk_idx   <= '0;
      stk_state <= '0;
      stk_pc    <= '0;
      stk_npc   <= '0;
      stk_tt    <= '0;
    end else begin
      stk_we <= accept;
      if (accept) begin
        stk_idx   <= idx_next;
        stk_state <= cur_state;
        stk_pc    <= cur_pc;
        stk_npc   <= cur_npc;
        stk_tt    <= trap_type;
      end
    end
  end

  assert_stack_index_R4: assert property (@(posedge clk) disable iff (rst)
    stk_we |-> (stk_idx == IDX_W'(trap_level)));

  assert_vector_type_R5: assert property (@(posedge clk) disable iff (rst)
    stk_we |-> (new_pc[13:5] == stk_tt && new_pc[4:0] == 5'd0));

  assert_idle_no_write_R13: assert property (@(posedge clk) disable iff (rst)
    !trap_req |=> (!stk_we && $stable(trap_level) && $stable(new_pc) && $stable(new_cwp)));

  assert_write_single_R4: assert property (@(posedge clk) disable iff (rst)
    stk_we |=> (!stk_we || $past(trap_req)));

endmodule

// File: tb/trap_entry_seq_bench.sv
`timescale 1ns/1ps
module trap_entry_seq_bench;

  localparam int AW = 64;
  localparam int SW = 32;
  localparam int TLW = 4;
  localparam int IW = 3;
  localparam int NW = 8;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trap_req = 1'b0;
  logic [8:0] trap_type = '0;
  logic [AW-1:0] cur_pc = '0, cur_npc = '0;
  logic [SW-1:0] cur_state = '0;
  logic [CW-1:0] cur_cwp = '0, cur_cansave = '0;
  logic [AW-1:0] trap_base = 64'hFEDC_BA98_7654_FFFF;
  logic [AW-1:0] hyp_trap_base = 64'h0123_4567_89AB_FFFF;
  logic hyp_mode = 1'b0;
  logic [TLW-1:0] max_level = 4'd15;
  logic [AW-1:0] new_pc, new_npc, stk_pc, stk_npc;
  logic [TLW-1:0] trap_level;
  logic error_state, red_state, stk_we;
  logic [CW-1:0] new_cwp;
  logic [IW-1:0] stk_idx;
  logic [SW-1:0] stk_state;
  logic [8:0] stk_tt;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int seq = 0;

  // bench model
  logic [TLW-1:0] m_tl;
  logic m_red, m_err;
  logic [AW-1:0] m_pc, m_npc;
  logic [CW-1:0] m_cwp;

  trap_entry_seq #(.ADDR_W(AW), .STATE_W(SW), .TL_W(TLW), .IDX_W(IW), .NWIN(NW)) u_trap_entry_seq (
    .clk(clk), .rst(rst), .trap_req(trap_req), .trap_type(trap_type),
    .cur_pc(cur_pc), .cur_npc(cur_npc), .cur_state(cur_state), .cur_cwp(cur_cwp),
    .cur_cansave(cur_cansave), .trap_base(trap_base), .hyp_trap_base(hyp_trap_base),
    .hyp_mode(hyp_mode), .max_level(max_level), .new_pc(new_pc), .new_npc(new_npc),
    .trap_level(trap_level), .error_state(error_state), .red_state(red_state),
    .new_cwp(new_cwp), .stk_we(stk_we), .stk_idx(stk_idx), .stk_state(stk_state),
    .stk_pc(stk_pc), .stk_npc(stk_npc), .stk_tt(stk_tt)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    trap_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_tl = '0; m_red = 0; m_err = 0; m_pc = '0; m_npc = '0; m_cwp = '0;
  endtask

  function automatic logic [CW-1:0] exp_cwp(input logic [8:0] tt, input int cw, input int cs);
    if (tt == 9'h024) return CW'((cw - 1) % NW + NW);
    if (tt[8:6] == 3'b010) return CW'((cw - cs - 2 + 2 * NW) % NW);
    if (tt[8:6] == 3'b011) return CW'((cw + 1) % NW);
    return CW'(cw);
  endfunction

  task automatic take(input logic [8:0] tt, input logic hyp, input int cw, input int cs);
    bit acc;
    bit last;
    logic [IW-1:0] e_idx;
    logic [AW-1:0] e_spc, e_snpc;
    logic [SW-1:0] e_st;
    seq++;
    @(negedge clk);
    trap_type = tt;
    hyp_mode = hyp;
    cur_cwp = CW'(cw);
    cur_cansave = CW'(cs);
    cur_pc = 64'h0000_4000_0000_0000 + 64'(seq) * 64'h10;
    cur_npc = cur_pc + 64'h4;
    cur_state = 32'hA5A5_0000 ^ SW'(seq * 977);
    e_spc = cur_pc; e_snpc = cur_npc; e_st = cur_state;
    trap_req = 1'b1;
    acc = (m_tl < max_level);
    if (!acc) begin
      m_err = 1;
    end else begin
      last = (int'(m_tl) + 1 >= int'(max_level));
      if (last) m_red = 1;
      m_tl = m_tl + 1;
      if (hyp) m_pc = (hyp_trap_base & ~64'h3fff) | 64'({tt, 5'b0});
      else m_pc = (trap_base & ~64'h7fff) | 64'({tt, 5'b0}) | ((m_tl > 1) ? 64'h4000 : 64'h0);
      m_npc = m_pc + 64'd4;
      m_cwp = exp_cwp(tt, cw, cs);
    end
    e_idx = m_tl[IW-1:0];
    @(negedge clk);
    trap_req = 1'b0;
    chk(trap_level == m_tl, acc ? "R2/R3 level" : "R1 level", 64'(trap_level), 64'(m_tl));
    chk(red_state == m_red, "R3 red", 64'(red_state), 64'(m_red));
    chk(error_state == m_err, "R1 error", 64'(error_state), 64'(m_err));
    chk(new_pc == m_pc, hyp ? "R6 vector" : "R5 vector", new_pc, m_pc);
    chk(new_npc == m_npc, "R7 npc", new_npc, m_npc);
    chk(new_cwp == m_cwp, "R8-R11 window", 64'(new_cwp), 64'(m_cwp));
    chk(stk_we == acc, acc ? "R4 write" : "R1 no write", 64'(stk_we), 64'(acc));
    if (acc) begin
      chk(stk_idx == e_idx, "R4 index", 64'(stk_idx), 64'(e_idx));
      chk(stk_pc == e_spc && stk_npc == e_snpc, "R4 pcs", stk_pc, e_spc);
      chk(stk_tt == tt && stk_state == e_st, "R4 type/state", 64'(stk_tt), 64'(tt));
    end
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk(!stk_we, "R13 no write", 64'(stk_we), 0);
    chk(trap_level == m_tl && new_pc == m_pc && new_cwp == m_cwp && red_state == m_red,
        "R13 stable", new_pc, m_pc);
  endtask

  initial begin
    int maxes [6] = '{0, 1, 2, 3, 5, 15};
    do_reset();
    // R12: reset state
    chk(trap_level == 0 && !red_state && !error_state, "R12 flags", 64'(trap_level), 0);
    chk(!stk_we && new_pc == 0 && new_npc == 0 && new_cwp == 0, "R12 outputs", new_pc, 0);

    // level climb for several maxima, through max and into the error state
    foreach (maxes[k]) begin
      max_level = TLW'(maxes[k]);
      do_reset();
      for (int i = 0; i < maxes[k] + 2; i++) begin
        take(9'((i * 37 + 5) & 9'h1ff), logic'(i % 2), (i * 3) % NW, i % NW);
        idle_check();
      end
    end

    // window sweep: every pointer and can-save pair for each trap class
    max_level = 4'd15;
    for (int cw = 0; cw < NW; cw++) begin
      for (int cs = 0; cs < NW; cs++) begin
        do_reset();
        take(9'h084 | 9'(cs), 1'b0, cw, cs);   // R9 spill
        take(9'h0C0 | 9'(cw), 1'b1, cw, cs);   // R10 fill
        take(9'h024, 1'b0, cw, cs);            // R8 clean window
        take(9'h041 + 9'(cs), 1'b1, cw, cs);   // R11 other
      end
    end

    report();
  end

endmodule